// File: doc/BRIEF.md
# Timer Channel Status Flags with Guarded Clearing

This block is one channel of a 16-bit timer together with its event flags. A counter advances on every clock. Four general registers each work either as a compare value or as a capture target. When the counter matches a register in compare mode, or a capture pin edge copies the counter into a register in capture mode, the flag of that register is raised. A fifth flag records counter wraparound. Each flag drives a level interrupt request, gated by its own enable bit.

Software reaches the channel through a byte-wide register port. A flag is only cleared by a zero write if the same flag was seen at one by an earlier read of the status byte. This stops a write from discarding an event that software never observed. A data-transfer controller that services one of the four register interrupts can also clear the matching flag by acknowledging, unless its clear-disable input is held high. When a set and a clear meet in one cycle, the set is kept.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset the status byte reads 0xC0, all interrupt requests are low, every general register reads 0xFFFF, and the enable and mode registers read 0x00.
- R2: The counter increases by one every clock. A write to the counter high byte (offset 0x6) is held, and a write to the low byte (offset 0x7) loads both bytes at once. Reads of offsets 0x6 and 0x7 return the live counter bytes.
- R3: The overflow flag (status bit 4) is set on the clock edge where the counter goes from 0xFFFF to 0x0000.
- R4: A general register in compare mode (its mode bit at 0) sets its flag on the edge after the cycle in which the counter equals the register. The mode register is at offset 0x1, with bit n for register n (A=0 … D=3). The registers sit at offset 0x8+2n (high byte, held) and 0x9+2n (low byte, loads both).
- R5: A register in capture mode (mode bit 1) loads the counter value and sets its flag on the third clock edge after its capture pin rises. Such a register never sets its flag on a counter match.
- R6: Status bits 7 and 6 always read 1 and bit 5 always reads 0. Bits 3..0 hold the flags of registers D, C, B and A, and bit 4 holds the overflow flag. The status byte is at offset 0x5.
- R7: Reading the status byte arms each flag that reads as 1. A later status write with 0 in a bit clears that flag only if it is armed. Any status write disarms all flags.
- R8: Writing 1 to a status flag bit has no effect on that flag.
- R9: An acknowledge on the transfer-controller input for register n clears flag n when the clear-disable input is 0. It does nothing when the clear-disable input is 1. No acknowledge path reaches the overflow flag.
- R10: A set event and a clear of the same flag in the same cycle leave the flag at 1.
- R11: Each interrupt request is the matching flag ANDed with its enable bit. The enable register is at offset 0x4 and uses the status bit layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cap_pin | input | 4 | Asynchronous capture inputs, one per general register |
| dtc_ack | input | 4 | Transfer-controller service acknowledge, one per general register |
| dtc_clr_dis | input | 1 | When high, acknowledges leave flags untouched |
| irq | output | 5 | Interrupt requests, bit layout as the status byte |

## Verification
The properties assume that a read and a write never happen in the same cycle, since bus_wr selects one or the other. They also assume that an acknowledge is a single-cycle pulse tied to one serviced event. The stimulus changes every input only at the falling edge and drives one bus access at a time, so each operation spans a whole clock period. Capture pins are held high for several cycles before they are released, so the synchroniser sees one clean rising edge for each pulse. Counter loads are placed away from the register values under test, so that no stray match sets a flag during a check.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_GR  = 4;
  localparam int NUM_FLG = NUM_GR + 1;
  localparam int OVF_BIT = NUM_GR;
  localparam int ADDR_W  = 4;
  localparam int BYTE_W  = 8;

  localparam logic [ADDR_W-1:0] A_MODE    = 4'h1;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'h5;
  localparam logic [ADDR_W-1:0] A_CNT_H   = 4'h6;
  localparam logic [ADDR_W-1:0] A_CNT_L   = 4'h7;
  localparam int                A_GR_BASE = 8;

  function automatic logic [ADDR_W-1:0] gr_hi_addr(input int idx);
    return ADDR_W'(A_GR_BASE + 2 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] gr_lo_addr(input int idx);
    return ADDR_W'(A_GR_BASE + 2 * idx + 1);
  endfunction

  function automatic logic is_hi_byte(input logic [ADDR_W-1:0] a);
    return (a == A_CNT_H) || (a[3] && !a[0]);
  endfunction

  function automatic logic [BYTE_W-1:0] stat_byte(input logic [NUM_FLG-1:0] f);
    return {2'b11, 1'b0, f};
  endfunction

  function automatic logic flag_bit_next(input logic set, input logic clr, input logic cur);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic is_wrap(input logic [CNT_W-1:0] c);
    return &c;
  endfunction
endpackage

// File: rtl/tfu_counter.sv
module tfu_counter
  import tfu_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap_ev
);
  assign wrap_ev = !load && is_wrap(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else           cnt_q <= cnt_step(cnt_q);
  end
endmodule

// File: rtl/tfu_gr_chan.sv
module tfu_gr_chan #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic         wr_load,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] cnt,
  input  logic         cap_pin,
  output logic [W-1:0] gr_q,
  output logic         hit_ev
);
  logic [SYNC:0] pin_sh;
  logic          pin_rise;
  logic          cap_ev;
  logic          cmp_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[SYNC-1:0], cap_pin};
  end

  assign pin_rise = pin_sh[SYNC-1] & ~pin_sh[SYNC];
  assign cap_ev   = cap_mode & pin_rise;
  assign cmp_ev   = !cap_mode && (cnt == gr_q);
  assign hit_ev   = cap_ev | cmp_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gr_q <= '1;
    else if (cap_ev)  gr_q <= cnt;
    else if (wr_load) gr_q <= wr_val;
  end
endmodule

// File: rtl/tfu_flag_bank.sv
module tfu_flag_bank
  import tfu_pkg::*;
#(
  parameter int N = NUM_FLG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] ack_clr,
  input  logic         rd_arm,
  input  logic         wr_clr,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] armed_q
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic sw_clr;
    assign sw_clr = wr_clr & armed_q[g] & ~wr_bits[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g]  <= 1'b0;
        armed_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_bit_next(set_ev[g], sw_clr | ack_clr[g], flag_q[g]);
        if (rd_arm)      armed_q[g] <= flag_q[g];
        else if (wr_clr) armed_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tfu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NUM_GR-1:0] cap_pin,
  input  logic [NUM_GR-1:0] dtc_ack,
  input  logic              dtc_clr_dis,
  output logic [NUM_FLG-1:0] irq
);
  logic               wr_cyc, rd_cyc;
  logic               stat_wr, stat_rd;
  logic [BYTE_W-1:0]  hold_q;
  logic [NUM_GR-1:0]  mode_q;
  logic [NUM_FLG-1:0] ien_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_ld;
  logic               wrap_ev;
  logic [CNT_W-1:0]   ld_val;
  logic [CNT_W-1:0]   gr_q [NUM_GR];
  logic [NUM_GR-1:0]  hit_ev;
  logic [NUM_FLG-1:0] set_ev;
  logic [NUM_FLG-1:0] ack_clr;
  logic [NUM_FLG-1:0] flag_q;
  logic [NUM_FLG-1:0] armed_q;

  assign wr_cyc  = bus_en & bus_wr;
  assign rd_cyc  = bus_en & ~bus_wr;
  assign stat_wr = wr_cyc && (bus_addr == A_STAT);
  assign stat_rd = rd_cyc && (bus_addr == A_STAT);
  assign cnt_ld  = wr_cyc && (bus_addr == A_CNT_L);
  assign ld_val  = {hold_q, bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      mode_q <= '0;
      ien_q  <= '0;
    end else if (wr_cyc) begin
      if (is_hi_byte(bus_addr)) hold_q <= bus_wdata;
      if (bus_addr == A_MODE)   mode_q <= bus_wdata[NUM_GR-1:0];
      if (bus_addr == A_IEN)    ien_q  <= bus_wdata[NUM_FLG-1:0];
    end
  end

  tfu_counter #(.W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_ld),
    .load_val (ld_val),
    .cnt_q    (cnt_q),
    .wrap_ev  (wrap_ev)
  );

  for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
    logic gr_ld;
    assign gr_ld = wr_cyc && (bus_addr == gr_lo_addr(i));

    tfu_gr_chan #(.W(CNT_W), .SYNC(SYNC_STAGES)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_mode (mode_q[i]),
      .wr_load  (gr_ld),
      .wr_val   (ld_val),
      .cnt      (cnt_q),
      .cap_pin  (cap_pin[i]),
      .gr_q     (gr_q[i]),
      .hit_ev   (hit_ev[i])
    );
  end

  assign set_ev  = {wrap_ev, hit_ev};
  assign ack_clr = {1'b0, dtc_ack & {NUM_GR{~dtc_clr_dis}}};

  tfu_flag_bank #(.N(NUM_FLG)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .ack_clr (ack_clr),
    .rd_arm  (stat_rd),
    .wr_clr  (stat_wr),
    .wr_bits (bus_wdata[NUM_FLG-1:0]),
    .flag_q  (flag_q),
    .armed_q (armed_q)
  );

  assign irq = flag_q & ien_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_STAT:  bus_rdata = stat_byte(flag_q);
      A_IEN:   bus_rdata = BYTE_W'(ien_q);
      A_MODE:  bus_rdata = BYTE_W'(mode_q);
      A_CNT_H: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
      A_CNT_L: bus_rdata = cnt_q[BYTE_W-1:0];
      default: begin
        for (int i = 0; i < NUM_GR; i++) begin
          if (bus_addr == gr_hi_addr(i)) bus_rdata = gr_q[i][CNT_W-1:BYTE_W];
          if (bus_addr == gr_lo_addr(i)) bus_rdata = gr_q[i][BYTE_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/tfu_checker.sv
module tfu_checker
  import tfu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BYTE_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [NUM_FLG-1:0] flag_q,
  input logic [NUM_FLG-1:0] armed_q,
  input logic [NUM_FLG-1:0] set_ev,
  input logic [NUM_GR-1:0]  dtc_ack,
  input logic               dtc_clr_dis
);
  logic stat_w, cnt_w;
  assign stat_w = bus_en && bus_wr && (bus_addr == A_STAT);
  assign cnt_w  = bus_en && bus_wr && (bus_addr == A_CNT_L);

  // R3
  wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q && !cnt_w) |=> (flag_q[OVF_BIT] && cnt_q == '0));

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev != '0) |=> ((flag_q & $past(set_ev)) == $past(set_ev)));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtc_clr_dis && ((dtc_ack & ~set_ev[NUM_GR-1:0]) != '0))
    |=> ((flag_q[NUM_GR-1:0] & $past(dtc_ack & ~set_ev[NUM_GR-1:0])) == '0));

  // R9
  ack_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtc_clr_dis && !stat_w)
    |=> ((flag_q[NUM_GR-1:0] & $past(flag_q[NUM_GR-1:0])) == $past(flag_q[NUM_GR-1:0])));

  // R8
  ones_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && (&bus_wdata[NUM_FLG-1:0]) && (dtc_clr_dis || dtc_ack == '0))
    |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R7
  write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_w |=> (armed_q == '0));

  // R7
  ovf_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[OVF_BIT] && !(stat_w && armed_q[OVF_BIT] && !bus_wdata[OVF_BIT]))
    |=> flag_q[OVF_BIT]);
endmodule

bind tmr_flag_unit tfu_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .cnt_q       (cnt_q),
  .flag_q      (flag_q),
  .armed_q     (armed_q),
  .set_ev      (set_ev),
  .dtc_ack     (dtc_ack),
  .dtc_clr_dis (dtc_clr_dis)
);

// File: tb/tmr_flag_unit_tb.sv
module tmr_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] AD_MODE = 4'h1;
  localparam logic [3:0] AD_IEN  = 4'h4;
  localparam logic [3:0] AD_STAT = 4'h5;
  localparam logic [3:0] AD_CH   = 4'h6;
  localparam logic [3:0] AD_CL   = 4'h7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] cap_pin = '0;
  logic [3:0] dtc_ack = '0;
  logic       dtc_clr_dis = 1'b0;
  logic [4:0] irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .dtc_ack(dtc_ack), .dtc_clr_dis(dtc_clr_dis), .irq(irq)
  );

  function automatic logic [3:0] ghi(input int n); return 4'(8 + 2 * n); endfunction
  function automatic logic [3:0] glo(input int n); return 4'(9 + 2 * n); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic load16(input logic [3:0] ah, input logic [3:0] al, input logic [15:0] v);
    wr(ah, v[15:8]);
    wr(al, v[7:0]);
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd(AD_STAT, d);
    wr(AD_STAT, 8'h00);
  endtask

  task automatic pulse_cap(input int n);
    cap_pin[n] = 1'b1;
    repeat (4) @(negedge clk);
    cap_pin[n] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(AD_STAT, d);  chk("R1 status after reset", d, 8'hC0);
    chk("R1 irq after reset", irq, 5'h00);
    rd(glo(0), d);   chk("R1 reg A low after reset", d, 8'hFF);
    rd(ghi(3), d);   chk("R1 reg D high after reset", d, 8'hFF);
    rd(AD_IEN, d);   chk("R1 enable after reset", d, 8'h00);
    wr(AD_STAT, 8'hFF);
    rd(AD_STAT, d);  chk("R6 fixed bits after ones write", d, 8'hC0);
  endtask

  task automatic t_counter();
    logic [7:0] d;
    load16(AD_CH, AD_CL, 16'h12FE);
    rd(AD_CL, d);  chk("R2 counter low one clock after load", d, 8'hFF);
    rd(AD_CH, d);  chk("R2 counter high after carry", d, 8'h13);
  endtask

  task automatic t_overflow();
    wr(AD_IEN, 8'h10);
    load16(AD_CH, AD_CL, 16'hFFFE);
    chk("R3 no overflow at FFFE", irq[4], 1'b0);
    @(negedge clk);
    chk("R3 no overflow at FFFF", irq[4], 1'b0);
    @(negedge clk);
    chk("R3 overflow after wrap", irq[4], 1'b1);
    clear_all();
    chk("R7 overflow cleared after armed zero write", irq[4], 1'b0);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_compare();
    wr(AD_MODE, 8'h00);
    load16(ghi(0), glo(0), 16'h1000);
    wr(AD_IEN, 8'h01);
    load16(AD_CH, AD_CL, 16'h0800);
    clear_all();
    load16(AD_CH, AD_CL, 16'h0FFD);
    repeat (3) @(negedge clk);
    chk("R4 no flag while counter equals register", irq[0], 1'b0);
    @(negedge clk);
    chk("R4 flag on edge after match", irq[0], 1'b1);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_capture();
    logic [7:0] d;
    load16(ghi(3), glo(3), 16'h3005);
    wr(AD_MODE, 8'h0A);
    clear_all();
    wr(AD_IEN, 8'h0A);
    load16(AD_CH, AD_CL, 16'h3000);
    cap_pin[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 no capture flag before third edge", irq[1], 1'b0);
    @(negedge clk);
    chk("R5 capture flag on third edge", irq[1], 1'b1);
    rd(ghi(1), d);  chk("R5 captured high byte", d, 8'h30);
    rd(glo(1), d);  chk("R5 captured low byte", d, 8'h02);
    cap_pin[1] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 capture-mode register ignores counter match", irq[3], 1'b0);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_arm();
    logic [7:0] d;
    wr(AD_MODE, 8'h0F);
    clear_all();
    pulse_cap(0);
    rd(AD_STAT, d);  chk("R6 status shows flag A", d, 8'hC1);
    pulse_cap(1);
    wr(AD_STAT, 8'h00);
    rd(AD_STAT, d);  chk("R7 unarmed flag B kept, armed A cleared", d, 8'hC2);
    wr(AD_IEN, 8'h02);
    wr(AD_STAT, 8'hFF);
    chk("R8 ones write leaves flag B", irq[1], 1'b1);
    wr(AD_STAT, 8'h00);
    chk("R7 write after disarming leaves flag B", irq[1], 1'b1);
    clear_all();
    chk("R7 rearmed flag B cleared", irq[1], 1'b0);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_dtc();
    wr(AD_IEN, 8'h14);
    clear_all();
    pulse_cap(2);
    chk("R9 flag C set by capture", irq[2], 1'b1);
    dtc_clr_dis = 1'b1; dtc_ack[2] = 1'b1;
    @(negedge clk);
    dtc_ack = '0;
    chk("R9 acknowledge ignored when disabled", irq[2], 1'b1);
    dtc_clr_dis = 1'b0; dtc_ack[2] = 1'b1;
    @(negedge clk);
    dtc_ack = '0;
    chk("R9 acknowledge clears flag C", irq[2], 1'b0);
    load16(AD_CH, AD_CL, 16'hFFFF);
    @(negedge clk);
    chk("R9 overflow flag set for ack test", irq[4], 1'b1);
    dtc_ack = 4'hF;
    @(negedge clk);
    dtc_ack = '0;
    chk("R9 acknowledges leave overflow flag", irq[4], 1'b1);
    load16(AD_CH, AD_CL, 16'h4000);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_set_wins();
    wr(AD_IEN, 8'h08);
    clear_all();
    cap_pin[3] = 1'b1;
    repeat (2) @(negedge clk);
    dtc_clr_dis = 1'b0; dtc_ack[3] = 1'b1;
    @(negedge clk);
    dtc_ack = '0;
    chk("R10 capture beats acknowledge in same cycle", irq[3], 1'b1);
    cap_pin[3] = 1'b0;
    dtc_ack[3] = 1'b1;
    @(negedge clk);
    dtc_ack = '0;
    chk("R10 lone acknowledge then clears", irq[3], 1'b0);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    clear_all();
    pulse_cap(0);
    chk("R11 request masked while enable low", irq, 5'h00);
    wr(AD_IEN, 8'h01);
    chk("R11 request follows enable", irq, 5'h01);
    rd(AD_IEN, d);  chk("R11 enable readback", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counter();
    t_overflow();
    t_compare();
    t_capture();
    t_arm();
    t_dtc();
    t_set_wins();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule